// File: doc/BRIEF.md
# Keyboard Scan Code Receiver

This block takes the serial line from a keyboard and turns each frame into one scan code byte. The line goes through a synchroniser. A bit timer, set from a programmable divider, samples each bit at the middle of its period. The data and parity bits are shifted into a register. The start, parity and stop bits are removed, and the block checks that the frame is well formed before it keeps the byte.

A good byte is placed in a holding register. The block then raises `code_irq`, which is also the valid side of a valid/ready pair towards the host. The host takes the byte by pulsing `code_ready` while `code_irq` is high. Until it does, `code_irq` stays high and the byte and its release flag do not change. A new byte that arrives in that time is dropped and recorded as an overrun. The serial side has no back-pressure. The byte 0xF0 marks a key release: the block holds it back and tags the next code with `code_release` instead.

Top module: `kbd_code_rx`

## Requirements
- R1: A frame is a 0 start bit, 8 data bits sent least significant bit first, an odd parity bit, and a 1 stop bit. A good frame places its data byte on `code_data` and raises `code_irq`.
- R2: One bit lasts `clk_div` clock cycles (4 or more), and each bit is sampled at mid-bit. Changing `clk_div` while the line is idle changes the bit rate the block accepts.
- R3: A low pulse on the line that is gone before half a bit period has passed is not taken as a start bit. No byte and no error flag result from it.
- R4: When the 8 data bits and the parity bit together hold an even number of ones, `err_parity` sets, the byte is dropped and `code_irq` is not raised.
- R5: When the stop bit is sampled as 0, `err_frame` sets, the byte is dropped and `code_irq` is not raised.
- R6: A good byte of 0xF0 is not reported. The next good byte is reported with `code_release` = 1. A byte with no 0xF0 before it has `code_release` = 0. A second 0xF0 that follows a 0xF0 is reported as code 0xF0 with `code_release` = 1.
- R7: While `code_ready` is low, `code_irq` stays high and `code_data` and `code_release` stay stable. `code_irq` is low in the cycle after a `code_ready` pulse.
- R8: When a good non-prefix frame completes while `code_irq` is high and `code_ready` is low, `err_overrun` sets and the older byte is kept.
- R9: A `code_ready` pulse clears `err_parity`, `err_frame` and `err_overrun`. A `code_ready` pulse while `code_irq` is low leaves `code_data` unchanged.
- R10: After reset, `code_irq`, `code_release`, all error flags and `code_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_div | input | DIV_W | Clock cycles per serial bit |
| ser_in | input | 1 | Serial line from the keyboard, idle high |
| code_data | output | 8 | Scan code held for the host |
| code_release | output | 1 | The held code belongs to a key release |
| code_irq | output | 1 | Interrupt request, also valid for the held code |
| code_ready | input | 1 | Host read strobe, acknowledges the held code |
| err_parity | output | 1 | Sticky parity error flag |
| err_frame | output | 1 | Sticky stop bit error flag |
| err_overrun | output | 1 | Sticky overrun flag |

## Verification
A bit timer that is off by a count, or a shift that runs the wrong way, shows up as a wrong byte or a parity error in the first frame after reset. This is visible at most a few cycles after that frame's stop bit. A release marker that is stuck shows on `code_release` with the very next byte. A holding register that accepts new data while the interrupt is pending shows at the ports as a changed byte instead of the overrun flag. A receiver that does not return to idle after a bad stop bit, or that accepts a short glitch as a start bit, gives the wrong result for the next frame that follows.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned SHIFT_W = CODE_W + 1;
  localparam logic [CODE_W-1:0] RELEASE_PREFIX = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP,
    ST_RECOVER
  } rx_state_e;

  typedef struct packed {
    logic [CODE_W-1:0] data;
    logic              par_ok;
    logic              stop_ok;
  } frame_res_t;
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_rx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             done_o,
  output frame_res_t       res_o
);
  localparam int unsigned IDX_W = $clog2(SHIFT_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SHIFT_W - 1);

  rx_state_e          state;
  logic [DIV_W-1:0]   cnt;
  logic [DIV_W-1:0]   target;
  logic [IDX_W-1:0]   bit_idx;
  logic [SHIFT_W-1:0] shreg;
  logic               tick;

  always_comb begin
    target = (state == ST_START) ? (div_i >> 1) : div_i;
    tick   = (cnt == target - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      done_o  <= 1'b0;
      res_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!line_i) state <= ST_START;
        end
        ST_START: begin
          if (tick) begin
            cnt <= '0;
            bit_idx <= '0;
            state <= line_i ? ST_IDLE : ST_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (tick) begin
            cnt   <= '0;
            shreg <= {line_i, shreg[SHIFT_W-1:1]};
            if (bit_idx == LAST_IDX) state <= ST_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tick) begin
            cnt           <= '0;
            done_o        <= 1'b1;
            res_o.data    <= shreg[CODE_W-1:0];
            res_o.par_ok  <= ^shreg;
            res_o.stop_ok <= line_i;
            state         <= ST_RECOVER;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RECOVER: begin
          if (line_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kbd_code_hold.sv
module kbd_code_hold
  import kbd_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  frame_res_t        res_i,
  input  logic              ready_i,
  output logic [CODE_W-1:0] data_o,
  output logic              release_o,
  output logic              irq_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              ovr_o
);
  logic pend_rel;
  logic good;
  logic is_prefix;
  logic busy;

  always_comb begin
    good      = done_i && res_i.par_ok && res_i.stop_ok;
    is_prefix = (res_i.data == RELEASE_PREFIX) && !pend_rel;
    busy      = irq_o && !ready_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o    <= '0;
      release_o <= 1'b0;
      irq_o     <= 1'b0;
      perr_o    <= 1'b0;
      ferr_o    <= 1'b0;
      ovr_o     <= 1'b0;
      pend_rel  <= 1'b0;
    end else begin
      if (ready_i) begin
        irq_o  <= 1'b0;
        perr_o <= 1'b0;
        ferr_o <= 1'b0;
        ovr_o  <= 1'b0;
      end
      if (done_i && !res_i.par_ok) perr_o <= 1'b1;
      if (done_i && !res_i.stop_ok) ferr_o <= 1'b1;
      if (good) begin
        if (is_prefix) begin
          pend_rel <= 1'b1;
        end else if (busy) begin
          ovr_o    <= 1'b1;
          pend_rel <= 1'b0;
        end else begin
          data_o    <= res_i.data;
          release_o <= pend_rel;
          irq_o     <= 1'b1;
          pend_rel  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/kbd_code_rx.sv
module kbd_code_rx
  import kbd_rx_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              ser_in,
  output logic [CODE_W-1:0] code_data,
  output logic              code_release,
  output logic              code_irq,
  input  logic              code_ready,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic       line_s;
  logic       frm_done;
  frame_res_t frm_res;

  kbd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ser_in), .q_o(line_s)
  );

  kbd_frame_rx #(.DIV_W(DIV_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .line_i(line_s), .div_i(clk_div),
    .done_o(frm_done), .res_o(frm_res)
  );

  kbd_code_hold u_hold (
    .clk(clk), .rst_n(rst_n), .done_i(frm_done), .res_i(frm_res),
    .ready_i(code_ready), .data_o(code_data), .release_o(code_release),
    .irq_o(code_irq), .perr_o(err_parity), .ferr_o(err_frame),
    .ovr_o(err_overrun)
  );
endmodule

// File: rtl/kbd_code_rx_chk.sv
module kbd_code_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] code_data,
  input logic       code_release,
  input logic       code_irq,
  input logic       code_ready,
  input logic       err_parity,
  input logic       err_frame,
  input logic       err_overrun,
  input logic       frm_done,
  input logic       frm_par_ok,
  input logic       frm_stop_ok
);
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    code_irq && !code_ready |=> code_irq);

  assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    code_irq && !code_ready |=> $stable(code_data) && $stable(code_release));

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(code_irq) && !$past(code_ready));

  assert_parity_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && !frm_par_ok |=> err_parity);

  assert_frame_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && !frm_stop_ok |=> err_frame);

  assert_bad_no_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && !(frm_par_ok && frm_stop_ok) && !code_irq |=> !code_irq);
endmodule

bind kbd_code_rx kbd_code_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .code_data(code_data), .code_release(code_release),
  .code_irq(code_irq), .code_ready(code_ready), .err_parity(err_parity),
  .err_frame(err_frame), .err_overrun(err_overrun), .frm_done(frm_done),
  .frm_par_ok(frm_res.par_ok), .frm_stop_ok(frm_res.stop_ok)
);

// File: tb/kbd_code_rx_tb_top.sv
module kbd_code_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 16;

  // fields: [21:14] byte, [13] flip parity, [12] stop bit, [11] exp irq,
  //         [10] exp release, [9:2] exp data, [1] exp parity err, [0] exp frame err
  localparam logic [21:0] VEC [8] = '{
    {8'h1C, 1'b0, 1'b1, 1'b1, 1'b0, 8'h1C, 1'b0, 1'b0},
    {8'hF0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h1C, 1'b0, 1'b0},
    {8'h1C, 1'b0, 1'b1, 1'b1, 1'b1, 8'h1C, 1'b0, 1'b0},
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
    {8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0},
    {8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0},
    {8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1},
    {8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] clk_div = 16'd16;
  logic ser_in = 1'b1;
  logic code_ready = 1'b0;
  logic [7:0] code_data;
  logic code_release, code_irq, err_parity, err_frame, err_overrun;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_code_rx #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .ser_in(ser_in),
    .code_data(code_data), .code_release(code_release), .code_irq(code_irq),
    .code_ready(code_ready), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic b);
    ser_in = b;
    repeat (int'(clk_div)) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip, input logic stopv);
    hold_bit(1'b0);
    for (int k = 0; k < 8; k++) hold_bit(d[k]);
    hold_bit(~^d ^ flip);
    hold_bit(stopv);
    ser_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_ready();
    code_ready = 1'b1;
    @(negedge clk);
    code_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 irq", code_irq, 0);
    chk("R10 data", code_data, 0);
    chk("R10 flags", {code_release, err_parity, err_frame, err_overrun}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R4 R5 R6 R9 table walk
    for (int i = 0; i < 8; i++) begin
      logic [21:0] v;
      v = VEC[i];
      send_frame(v[21:14], v[13], v[12]);
      chk("R1 irq", code_irq, v[11]);
      chk("R6 release", code_release, v[10]);
      chk("R1 data", code_data, v[9:2]);
      chk("R4 parity flag", err_parity, v[1]);
      chk("R5 frame flag", err_frame, v[0]);
      pulse_ready();
      chk("R7 irq clears", code_irq, 0);
      chk("R9 flags clear", {err_parity, err_frame, err_overrun}, 0);
    end

    // R7 hold while unread
    send_frame(8'h11, 1'b0, 1'b1);
    repeat (50) @(negedge clk);
    chk("R7 irq held", code_irq, 1);
    chk("R7 data held", code_data, 8'h11);
    // R8 overrun keeps older byte
    send_frame(8'h22, 1'b0, 1'b1);
    chk("R8 overrun", err_overrun, 1);
    chk("R8 old byte", code_data, 8'h11);
    chk("R8 irq", code_irq, 1);
    pulse_ready();
    chk("R9 overrun cleared", err_overrun, 0);
    // R9 ready without pending code
    pulse_ready();
    chk("R9 data kept", code_data, 8'h11);
    chk("R9 irq low", code_irq, 0);

    // R3 short glitch
    ser_in = 1'b0;
    repeat (3) @(negedge clk);
    ser_in = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 no irq", code_irq, 0);
    chk("R3 no flags", {err_parity, err_frame}, 0);
    send_frame(8'h44, 1'b0, 1'b1);
    chk("R3 next frame", code_data, 8'h44);
    pulse_ready();

    // R6 double prefix
    send_frame(8'hF0, 1'b0, 1'b1);
    chk("R6 prefix hidden", code_irq, 0);
    send_frame(8'hF0, 1'b0, 1'b1);
    chk("R6 F0 released", {code_irq, code_release, code_data}, {1'b1, 1'b1, 8'hF0});
    pulse_ready();

    // R2 other divider
    clk_div = 16'd10;
    repeat (4) @(negedge clk);
    send_frame(8'h69, 1'b0, 1'b1);
    chk("R2 div10 data", code_data, 8'h69);
    chk("R2 div10 irq", code_irq, 1);
    chk("R2 div10 clean", {code_release, err_parity, err_frame}, 0);
    pulse_ready();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule